// File: doc/BRIEF.md
# Coded Power-of-Two CPU Clock Selector

This block derives the processor's clock enable from a fast master clock. A 3-bit speed code picks one of eight power-of-two divide ratios. A single counter chain supplies every candidate tap. One tap is chosen, and the enable is registered on the master clock. The processor therefore sees a pulse exactly one master cycle wide, once per selected period.

Software changes the speed by writing a new code through a one-cycle write strobe. The selector does not switch in the middle of a period. A new code waits in a pending slot until the period now running ends, and the next period starts from a cleared counter at the new ratio. The enable spacing therefore never shows a shortened or stretched period. The code map is not monotonic: the four low codes give the fast ratios, the four high codes give the slow ones, and divide-by-64 has no code.

Top module: `cpu_rate_sel`

## Requirements
- R1: Code 3'b011 gives an enable on every master cycle, 3'b010 gives one every 2 cycles, 3'b001 one every 4 cycles and 3'b000 one every 8 cycles.
- R2: Code 3'b100 gives an enable every 16 cycles, 3'b101 every 32, 3'b110 every 128 and 3'b111 every 256. No code gives a spacing of 64.
- R3: While rst_n is low, cpu_en is 0 and the active code is 3'b010. The first enable appears 2 master cycles after reset is released, on the second rising edge at which rst_n is high.
- R4: cpu_en is high for one master cycle per period. It stays low on the cycle after a pulse unless the ratio now in force is 1.
- R5: The code is captured only on a rising edge where wr_en is 1. With wr_en at 0, any change on wr_code leaves the enable spacing unchanged.
- R6: A write made during a period does not alter that period. The period completes at the old ratio, and every later period uses the new one.
- R7: If several writes arrive within one period, only the last of them takes effect at the next boundary.
- R8: A write captured on the final cycle of a period takes effect at that same boundary, so the very next period already uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the speed code |
| wr_code | input | 3 | New speed code, sampled when wr_en is 1 |
| cpu_en | output | 1 | Processor clock enable, one master cycle wide per period |

## Verification
Two events can meet in one cycle: a register write and the last cycle of the running period, where the counter wraps and the active code is reloaded. The bench provokes this in two ways. It writes on the very pulse where the old ratio is 1, and it places a write exactly one cycle before the pulse of a /32 period. In both cases the next enable gap must already equal the new ratio. A mid-period double write, and toggling wr_code with wr_en low, show that only a strobed, last-written code reaches the boundary.

// File: rtl/cpu_rate_sel.sv
module cpu_rate_sel #(
  parameter int       CNT_W      = 8,
  parameter bit [2:0] RESET_CODE = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_code,
  output logic       cpu_en
);
  localparam int SEL_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   tap;
  logic [2:0]       act_code, pend_code, nxt_code;
  logic             pend_vld, tick;
  logic [SEL_W-1:0] sel;

  // code to log2 of the divide ratio; the map is non-monotonic
  function automatic logic [SEL_W-1:0] code_shift(input logic [2:0] c);
    case (c)
      3'b000:  return SEL_W'(3);
      3'b001:  return SEL_W'(2);
      3'b010:  return SEL_W'(1);
      3'b011:  return SEL_W'(0);
      3'b100:  return SEL_W'(4);
      3'b101:  return SEL_W'(5);
      3'b110:  return SEL_W'(7);
      default: return SEL_W'(8);
    endcase
  endfunction

  assign tap[0] = 1'b1;
  for (genvar k = 1; k <= CNT_W; k++) begin : g_tap
    assign tap[k] = &cnt[k-1:0];
  end

  assign sel      = code_shift(act_code);
  assign tick     = tap[sel];
  assign nxt_code = wr_en ? wr_code : pend_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_code  <= RESET_CODE;
      pend_code <= RESET_CODE;
      pend_vld  <= 1'b0;
      cpu_en    <= 1'b0;
    end else begin
      cpu_en <= tick;
      if (wr_en) pend_code <= wr_code;
      if (tick) begin
        cnt      <= '0;
        pend_vld <= 1'b0;
        if (wr_en || pend_vld) act_code <= nxt_code;
      end else begin
        cnt <= cnt + 1'b1;
        if (wr_en) pend_vld <= 1'b1;
      end
    end
  end
endmodule

module cpu_rate_sel_chk #(
  parameter int CNT_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       pend_vld,
  input logic [2:0] act_code,
  input logic       cpu_en
);
  logic [CNT_W+1:0] span;

  function automatic logic [CNT_W+1:0] ratio(input logic [2:0] c);
    case (c)
      3'b000:  return (CNT_W+2)'(8);
      3'b001:  return (CNT_W+2)'(4);
      3'b010:  return (CNT_W+2)'(2);
      3'b011:  return (CNT_W+2)'(1);
      3'b100:  return (CNT_W+2)'(16);
      3'b101:  return (CNT_W+2)'(32);
      3'b110:  return (CNT_W+2)'(128);
      default: return (CNT_W+2)'(256);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) span <= '0;
    else        span <= cpu_en ? (CNT_W+2)'(1) : span + 1'b1;

  // R1 R2 R3: every gap equals the ratio of the code that ran the period
  a_r1_span: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |-> span == ratio($past(act_code)));
  a_r3_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> !cpu_en);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && act_code != 3'b011) |=> !cpu_en);
  a_r5_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !pend_vld) |=> $stable(act_code));
  a_r6_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_code) |-> cpu_en);
endmodule

bind cpu_rate_sel cpu_rate_sel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pend_vld(pend_vld),
  .act_code(act_code), .cpu_en(cpu_en)
);

// File: tb/cpu_rate_sel_tb_top.sv
module cpu_rate_sel_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cpu_en;
  logic [2:0] wr_code = 3'b000;
  int checks = 0, errors = 0, cyc = 0, prev_t = 0;
  int exp_q[$];
  string tag_q[$];
  logic [2:0] cur = 3'b010;
  bit done = 0;

  always #5 clk = ~clk;

  cpu_rate_sel dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
                      .wr_code(wr_code), .cpu_en(cpu_en));

  function automatic int ratio(input logic [2:0] c);
    case (c)
      3'b000: return 8;   3'b001: return 4;   3'b010: return 2;  3'b011: return 1;
      3'b100: return 16;  3'b101: return 32;  3'b110: return 128; default: return 256;
    endcase
  endfunction

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL end: %0d gaps unseen, expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (rst_n) cyc++;

  // monitor: measure gaps between pulses and compare with the queue
  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (cpu_en !== 1'b0) begin
        errors++;
        $display("FAIL R3 reset: cpu_en=%b expected 0", cpu_en);
      end
    end else if (cpu_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected pulse: gap=%0d expected none", cyc - prev_t);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cyc - prev_t != e) begin
          errors++;
          $display("FAIL %s: gap=%0d expected %0d", t, cyc - prev_t, e);
        end
      end
      prev_t = cyc;
    end
  end

  // driver: write at a pulse, optional second write d2 cycles later, watch n pulses
  task automatic prog(input bit w1, input logic [2:0] a, input int d2,
                      input logic [2:0] b, input int n, input string tag);
    logic [2:0] fin;
    int i, seen;
    fin = (d2 >= 0) ? b : (w1 ? a : cur);
    while (!cpu_en) @(negedge clk);
    #1;
    exp_q.push_back(ratio(cur)); tag_q.push_back({tag, " old period"});
    for (int k = 1; k < n; k++) begin
      exp_q.push_back(ratio(fin)); tag_q.push_back(tag);
    end
    wr_en = w1; wr_code = a;
    i = 0; seen = 0;
    while (seen < n) begin
      @(negedge clk);
      #1;
      i++;
      if (cpu_en) seen++;
      if (d2 >= 0 && i == d2) begin
        wr_en = 1'b1; wr_code = b;
      end else begin
        wr_en = 1'b0; wr_code = 3'(i);
      end
    end
    wr_en = 1'b0;
    cur = fin;
  endtask

  initial begin
    exp_q.push_back(2); tag_q.push_back("R3 first pulse after reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    prog(1, 3'b011, -1, 3'b000, 4, "R1 /1 every cycle R4");
    prog(1, 3'b000, -1, 3'b000, 3, "R1 /8");
    prog(1, 3'b001, -1, 3'b000, 3, "R1 /4");
    prog(1, 3'b010, -1, 3'b000, 3, "R1 /2");
    prog(1, 3'b100, -1, 3'b000, 3, "R2 /16");
    prog(1, 3'b101, -1, 3'b000, 3, "R2 /32");
    prog(1, 3'b110, -1, 3'b000, 3, "R2 /128");
    prog(1, 3'b111, -1, 3'b000, 2, "R2 /256");
    prog(1, 3'b011, -1, 3'b000, 3, "R6 /256 to /1");
    prog(1, 3'b111, -1, 3'b000, 2, "R8 /1 to /256 on pulse");
    prog(1, 3'b000, 20, 3'b101, 3, "R7 last write wins");
    prog(0, 3'b000, 31, 3'b100, 3, "R8 write on final cycle");
    prog(0, 3'b000, -1, 3'b000, 4, "R5 no strobe no change");
    prog(1, 3'b000, -1, 3'b000, 2, "R6 /16 to /8");
    prog(1, 3'b011, -1, 3'b000, 2, "R6 /8 to /1");
    prog(1, 3'b010, -1, 3'b000, 3, "R6 /1 to /2");
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end
endmodule